// File: doc/BRIEF.md
# Three-Table Microcode Sequencer

This block is the control core of a small microcoded processor. It holds a 6-bit microstate and three writable lookup tables. The primary table is indexed by the current microstate. Each primary word carries twenty control lines for the datapath and a 6-bit successor state. Two of those control lines are dispatch bits. The first dispatch bit hands the choice of successor to an opcode table, which has one entry for each 4-bit opcode. The second hands it to a condition table, which has one entry for a false compare and one for a true compare. With this split, a state does not have to be duplicated for every opcode and flag value. Only the states that dispatch read those inputs.

Software or a boot sequencer fills the tables through a single write port before the sequencer runs. The control lines come combinationally from the primary entry of the current state. A step enable lets the state register advance on chosen cycles only, so the machine can be single-stepped. A word that sets both dispatch bits is illegal. The block flags it and stays where it is.

Top module: `ucode_seq`

## Requirements
- R1: Synchronous active-high reset puts the state at 0 and clears every entry of all three tables, so `ctl` reads 0 after reset.
- R2: With `step_en` high and neither dispatch bit set in the current primary word, the next state is bits [5:0] of that word.
- R3: With `step_en` high and only the opcode-dispatch bit set (word bit 23, `ctl[17]`), the next state is the opcode-table entry addressed by `opcode`.
- R4: With `step_en` high and only the compare-dispatch bit set (word bit 24, `ctl[18]`), the next state is the condition-table entry addressed by `cmp_flag` (entry 0 for false, entry 1 for true).
- R5: When both dispatch bits are set in the current word, `err` is 1 and the state does not change, even with `step_en` high. Otherwise `err` is 0.
- R6: With `step_en` low, the state holds.
- R7: `ctl[k]` equals bit k+6 of the primary word for the current state, combinationally, for k = 0..19.
- R8: The write port writes on the rising edge when `ld_en` is high. `ld_sel` = 0 writes the primary table at `ld_addr` with all 26 bits. `ld_sel` = 1 writes the opcode table at `ld_addr[3:0]` with `ld_data[5:0]`. `ld_sel` = 2 writes the condition table at `ld_addr[0]` with `ld_data[5:0]`. `ld_sel` = 3 writes nothing. A write shows on the read side from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the state on this edge |
| opcode | input | 4 | Opcode for opcode-table dispatch |
| cmp_flag | input | 1 | Compare result for condition dispatch |
| ld_en | input | 1 | Table write strobe |
| ld_sel | input | 2 | Table select: 0 primary, 1 opcode, 2 condition, 3 none |
| ld_addr | input | 6 | Write address |
| ld_data | input | 26 | Write data |
| state | output | 6 | Current microstate |
| ctl | output | 20 | Control lines (primary word bits 25:6) |
| err | output | 1 | Both dispatch bits set in the current word |

## Verification
A small microprogram runs a fetch state, then an opcode dispatch, then a per-opcode state. One opcode leads into a compare dispatch. The same program is walked several times. Different opcodes show whether the opcode table is indexed by `opcode`. The same compare state with `cmp_flag` at 0 and then at 1 shows whether the condition table is indexed correctly and not swapped. Directed cases cover the illegal double dispatch, stepping disabled, reset clearing the tables, a write with the unused select, and a live rewrite of the fetch entry.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
    parameter int STATE_W = 6;
    parameter int OPC_W   = 4;
    parameter int CTL_W   = 20;
    localparam int WORD_W     = STATE_W + CTL_W;
    localparam int MAIN_DEPTH = 1 << STATE_W;
    localparam int SEQ_DEPTH  = 1 << OPC_W;
    localparam int CTL_OPDISP = 17;
    localparam int CTL_CMDISP = 18;

    typedef struct packed {
        logic [CTL_W-1:0]   ctl;
        logic [STATE_W-1:0] nxt;
    } uword_t;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_SEQ  = 2'd1,
        SRC_COND = 2'd2,
        SRC_BAD  = 2'd3
    } nsrc_e;

    typedef enum logic [1:0] {
        TBL_MAIN = 2'd0,
        TBL_SEQ  = 2'd1,
        TBL_COND = 2'd2,
        TBL_NONE = 2'd3
    } tbl_e;

    function automatic nsrc_e pick_src(input logic op_disp, input logic cm_disp);
        return nsrc_e'({cm_disp, op_disp});
    endfunction
endpackage

// File: rtl/ucode_table.sv
module ucode_table #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int DW    = 26
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ucode_next.sv
module ucode_next
    import ucode_pkg::*;
(
    input  uword_t             cur_word,
    input  logic [STATE_W-1:0] cur_state,
    input  logic [STATE_W-1:0] seq_state,
    input  logic [STATE_W-1:0] cond_state,
    input  logic               step_en,
    output logic [STATE_W-1:0] nxt_state,
    output logic               conflict
);
    nsrc_e src;

    always_comb begin
        src       = pick_src(cur_word.ctl[CTL_OPDISP], cur_word.ctl[CTL_CMDISP]);
        conflict  = (src == SRC_BAD);
        nxt_state = cur_state;
        if (step_en) begin
            unique case (src)
                SRC_MAIN: nxt_state = cur_word.nxt;
                SRC_SEQ:  nxt_state = seq_state;
                SRC_COND: nxt_state = cond_state;
                SRC_BAD:  nxt_state = cur_state;
            endcase
        end
    end
endmodule

// File: rtl/ucode_state_reg.sv
module ucode_state_reg
    import ucode_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] d,
    output logic [STATE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import ucode_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               cmp_flag,
    input  logic               ld_en,
    input  logic [1:0]         ld_sel,
    input  logic [STATE_W-1:0] ld_addr,
    input  logic [WORD_W-1:0]  ld_data,
    output logic [STATE_W-1:0] state,
    output logic [CTL_W-1:0]   ctl,
    output logic               err
);
    tbl_e               tsel;
    logic               we_main, we_seq, we_cond;
    logic [WORD_W-1:0]  main_raw;
    uword_t             cur_word;
    logic [STATE_W-1:0] seq_q, cond_q, main_nxt, nxt_state;

    assign tsel    = tbl_e'(ld_sel);
    assign we_main = ld_en && (tsel == TBL_MAIN);
    assign we_seq  = ld_en && (tsel == TBL_SEQ);
    assign we_cond = ld_en && (tsel == TBL_COND);

    ucode_table #(.DEPTH(MAIN_DEPTH), .AW(STATE_W), .DW(WORD_W)) u_main (
        .clk(clk), .rst(rst), .we(we_main), .waddr(ld_addr),
        .wdata(ld_data), .raddr(state), .rdata(main_raw)
    );

    ucode_table #(.DEPTH(SEQ_DEPTH), .AW(OPC_W), .DW(STATE_W)) u_seq (
        .clk(clk), .rst(rst), .we(we_seq), .waddr(ld_addr[OPC_W-1:0]),
        .wdata(ld_data[STATE_W-1:0]), .raddr(opcode), .rdata(seq_q)
    );

    ucode_table #(.DEPTH(2), .AW(1), .DW(STATE_W)) u_cond (
        .clk(clk), .rst(rst), .we(we_cond), .waddr(ld_addr[0]),
        .wdata(ld_data[STATE_W-1:0]), .raddr(cmp_flag), .rdata(cond_q)
    );

    assign cur_word = uword_t'(main_raw);
    assign main_nxt = cur_word.nxt;

    ucode_next u_next (
        .cur_word(cur_word), .cur_state(state), .seq_state(seq_q),
        .cond_state(cond_q), .step_en(step_en),
        .nxt_state(nxt_state), .conflict(err)
    );

    ucode_state_reg u_sreg (.clk(clk), .rst(rst), .d(nxt_state), .q(state));

    assign ctl = cur_word.ctl;
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk
    import ucode_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               step_en,
    input logic [STATE_W-1:0] state,
    input logic [CTL_W-1:0]   ctl,
    input logic               err,
    input logic [STATE_W-1:0] main_nxt,
    input logic [STATE_W-1:0] seq_q,
    input logic [STATE_W-1:0] cond_q
);
    assert_reset_zero_R1: assert property (@(posedge clk) rst |=> state == '0);

    assert_plain_next_R2: assert property (@(posedge clk) disable iff (rst)
        (step_en && !ctl[CTL_OPDISP] && !ctl[CTL_CMDISP]) |=> state == $past(main_nxt));

    assert_opcode_next_R3: assert property (@(posedge clk) disable iff (rst)
        (step_en && ctl[CTL_OPDISP] && !ctl[CTL_CMDISP]) |=> state == $past(seq_q));

    assert_cond_next_R4: assert property (@(posedge clk) disable iff (rst)
        (step_en && !ctl[CTL_OPDISP] && ctl[CTL_CMDISP]) |=> state == $past(cond_q));

    assert_conflict_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl[CTL_OPDISP] && ctl[CTL_CMDISP]) |=> $stable(state));

    assert_err_cause_R5: assert property (@(posedge clk) disable iff (rst)
        err |-> (ctl[CTL_OPDISP] && ctl[CTL_CMDISP]));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(state));
endmodule

bind ucode_seq ucode_seq_chk u_chk (
    .clk(clk), .rst(rst), .step_en(step_en), .state(state), .ctl(ctl),
    .err(err), .main_nxt(main_nxt), .seq_q(seq_q), .cond_q(cond_q)
);

// File: tb/ucode_seq_bench.sv
module ucode_seq_bench;
    logic        clk = 1'b0;
    logic        rst, step_en, cmp_flag, ld_en;
    logic [3:0]  opcode;
    logic [1:0]  ld_sel;
    logic [5:0]  ld_addr;
    logic [25:0] ld_data;
    logic [5:0]  state;
    logic [19:0] ctl;
    logic        err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [25:0] model [64];

    always #2 clk = ~clk;

    ucode_seq u_ucode_seq (
        .clk(clk), .rst(rst), .step_en(step_en), .opcode(opcode),
        .cmp_flag(cmp_flag), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data), .state(state),
        .ctl(ctl), .err(err)
    );

    // {opcode, cmp_flag, expected state after one step}
    localparam logic [10:0] VEC [14] = '{
        {4'd2,  1'b0, 6'd1},  {4'd2,  1'b0, 6'd10}, {4'd2,  1'b0, 6'd0},
        {4'd8,  1'b0, 6'd1},  {4'd8,  1'b0, 6'd16}, {4'd8,  1'b0, 6'd20},
        {4'd8,  1'b0, 6'd0},  {4'd8,  1'b1, 6'd1},  {4'd8,  1'b1, 6'd16},
        {4'd8,  1'b1, 6'd21}, {4'd8,  1'b1, 6'd0},  {4'd15, 1'b0, 6'd1},
        {4'd15, 1'b0, 6'd23}, {4'd15, 1'b0, 6'd0}
    };

    function automatic logic [25:0] mk(int s, int nx, bit opd, bit cmd);
        logic [25:0] w;
        w[5:0]  = 6'(nx);
        w[22:6] = 17'(s * 37 + 3);
        w[23]   = opd;
        w[24]   = cmd;
        w[25]   = 1'(s);
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [5:0] a, logic [25:0] d);
        ld_en = 1'b1; ld_sel = sel; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; step_en = 1'b0; cmp_flag = 1'b0; opcode = '0;
        ld_en = 1'b0; ld_sel = '0; ld_addr = '0; ld_data = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", 32'(state), 0);
        check("R1 tables cleared", 32'(ctl), 0);

        // microprogram (R8 loads)
        for (int s = 0; s < 64; s++) begin
            if (s == 0)       model[s] = mk(s, 1, 0, 0);
            else if (s == 1)  model[s] = mk(s, 0, 1, 0);
            else if (s == 16) model[s] = mk(s, 0, 0, 1);
            else if (s == 17) model[s] = mk(s, 0, 1, 1);
            else              model[s] = mk(s, 0, 0, 0);
            wr(2'd0, 6'(s), model[s]);
        end
        for (int op = 0; op < 16; op++) wr(2'd1, 6'(op), 26'(8 + op));
        wr(2'd2, 6'd0, 26'd20);
        wr(2'd2, 6'd1, 26'd21);

        // vector walk
        for (int i = 0; i < 14; i++) begin
            logic [25:0] w;
            w = model[state];
            check("R7 ctl mirrors word", 32'(ctl), 32'(w[25:6]));
            check("R5 err low", 32'(err), 0);
            opcode = VEC[i][10:7]; cmp_flag = VEC[i][6]; step_en = 1'b1;
            @(negedge clk);
            if (w[23])      check("R3 opcode dispatch", 32'(state), 32'(VEC[i][5:0]));
            else if (w[24]) check("R4 compare dispatch", 32'(state), 32'(VEC[i][5:0]));
            else            check("R2 next field", 32'(state), 32'(VEC[i][5:0]));
        end

        // R6 stall
        step_en = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R6 stall hold", 32'(state), 0);

        // R5 double dispatch
        step_en = 1'b1; opcode = 4'd9;
        @(negedge clk);
        check("R3 opcode 9", 32'(state), 1);
        @(negedge clk);
        check("R3 opcode 9 target", 32'(state), 17);
        check("R5 err raised", 32'(err), 1);
        @(negedge clk); @(negedge clk);
        check("R5 state held", 32'(state), 17);

        // R1 reset mid-run
        rst = 1'b1; step_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset returns to 0", 32'(state), 0);
        check("R1 reset clears primary", 32'(ctl), 0);
        check("R5 err low after reset", 32'(err), 0);

        // R8 unused select ignored
        wr(2'd3, 6'd0, '1);
        check("R8 select 3 ignored", 32'(ctl), 0);
        step_en = 1'b1;
        @(negedge clk);
        check("R8 select 3 left next field", 32'(state), 0);
        step_en = 1'b0;

        // R8 live primary write
        wr(2'd0, 6'd0, mk(0, 5, 0, 0));
        begin
            logic [25:0] w;
            w = mk(0, 5, 0, 0);
            check("R8 primary write visible", 32'(ctl), 32'(w[25:6]));
        end
        step_en = 1'b1;
        @(negedge clk);
        check("R8 R2 new next field", 32'(state), 5);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule